// File: doc/BRIEF.md
# Adaptive-Blanking Desaturation Fault Detector

This block supervises one gate channel of a power switch against short circuits. It takes the PWM gate command and a comparator input that is high while the switch's drain-source voltage sits above the desaturation threshold. It passes the command to the gate output for as long as no fault is present. On every turn-on it counts the clock cycles until the comparator reports that the voltage has fallen. That count, plus a safety margin and clamped to a fixed range, becomes the blanking window that hard-switching detection uses in the next on-interval. When the load current grows and the fall slows down, the window follows it up. When the fall speeds up again, the window follows it down.

Two fault types are detected. A hard-switching fault is a comparator that is still high once the blanking window has expired. A fault under load is a comparator that rises again after the fall while the command is still high. On either fault the gate output drops at once and stays low. A sticky flag with a fault code holds until software or a supervisor clears it while the command is low. The intended clock is 250 MHz, so one cycle is 4 ns and the 60-cycle default window is 240 ns.

Top module: `desat_guard`

## Requirements
- R1: While reset is held and immediately after it, `fault_out` is 0, `fault_code` is 2'b00 and `gate_out` is 0 while `pwm_in` is low.
- R2: With no fault latched, `gate_out` equals `pwm_in` in the same cycle.
- R3: The learned window is the fall offset plus SYNC_N plus FILT_LEN plus MARGIN cycles, which is the offset plus 14 with the defaults. The fall offset is the number of clock edges from the first edge that sees `pwm_in` high to the first edge that sees `desat_in` low. The value is committed on the edge that sees `pwm_in` fall after a completed fall, and it appears on `blank_len`.
- R4: During an on-interval, if the filtered comparator is still high on the edge where the cycle count since turn-on reaches `blank_len`, a hard-switching fault is latched.
- R5: The learned window follows the measurement in both directions: a slower fall raises `blank_len` and a faster one lowers it.
- R6: The learned window is clamped to the range 25 to 250 cycles.
- R7: After reset, and after a clear, `blank_len` is 60 cycles (240 ns).
- R8: After the fall, a comparator that returns high while `pwm_in` stays high latches a fault under load. With the default filter, `gate_out` is low 7 cycles after the raw input rises, which is within 72 ns.
- R9: `fault_code` is 2'b01 for a hard-switching fault and 2'b10 for a fault under load. It is nonzero only while `fault_out` is 1.
- R10: While a fault is latched, `gate_out` is 0 whatever `pwm_in` does, and `fault_out` stays 1.
- R11: `clr_in` clears the fault and restores the 60-cycle default only on an edge where `pwm_in` is low. A clear while `pwm_in` is high has no effect.
- R12: `blank_len` is not updated by an on-interval that ends before the fall is seen, or by one that ends in a fault.
- R13: A comparator pulse shorter than FILT_LEN cycles, in either direction, is ignored: it is neither taken as the fall nor as a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 250 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM gate command, synchronous to clk |
| desat_in | input | 1 | Raw desaturation comparator, high while the voltage is above the threshold |
| clr_in | input | 1 | Fault clear, acted on only while pwm_in is low |
| gate_out | output | 1 | Gate drive command after protection |
| fault_out | output | 1 | Sticky fault flag |
| fault_code | output | 2 | 01 hard-switching, 10 under load, 00 none |
| blank_len | output | 8 | Blanking window currently in force, in cycles |

## Verification
The comparator is driven with falls at several offsets after turn-on, both early and late. These show the learned window rising, falling and sitting at the lower clamp. A stepped ramp of slower falls drives the window into its upper clamp. Comparators that never fall, or that fall later than the learned window allows, separate hard-switching faults from the normal case. A comparator that rises again after the fall produces the under-load fault, and its gate cutoff cycle is checked exactly. Short pulses, too-short on-times and clears given with the command high or low show which stimuli must leave the window and the fault flag untouched.

// File: rtl/desat_pkg.sv
package desat_pkg;

   typedef enum logic [1:0] {
      DG_IDLE = 2'd0,
      DG_RISE = 2'd1,
      DG_COND = 2'd2,
      DG_TRIP = 2'd3
   } dg_state_e;

   typedef enum logic [1:0] {
      DG_FC_NONE = 2'b00,
      DG_FC_HARD = 2'b01,
      DG_FC_LOAD = 2'b10
   } dg_fcode_e;

endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/dg_filter.sv
module dg_filter #(
   parameter int   LEN     = 4,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic lvl_out
);

   localparam int FW = $clog2(LEN + 1);

   logic [FW-1:0] run_q;
   logic          lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= RST_VAL;
      end else if (d_in == lvl_q) begin
         run_q <= '0;
      end else if (run_q == FW'(LEN - 1)) begin
         run_q <= '0;
         lvl_q <= d_in;
      end else begin
         run_q <= run_q + FW'(1);
      end
   end

   assign lvl_out = lvl_q;

   // R13
   level_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(d_in)));

endmodule

// File: rtl/dg_learn.sv
module dg_learn #(
   parameter int W      = 8,
   parameter int DEF    = 60,
   parameter int MIN    = 25,
   parameter int MAX    = 250,
   parameter int MARGIN = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         commit,
   input  logic [W-1:0] meas,
   output logic [W-1:0] blank
);

   localparam int SW = W + 1;

   logic [SW-1:0] sum;
   logic [W-1:0]  clamped;
   logic [W-1:0]  blank_q;

   generate
      if (MARGIN == 0) begin : g_no_margin
         assign sum = {1'b0, meas};
      end else begin : g_margin
         assign sum = {1'b0, meas} + SW'(MARGIN);
      end
   endgenerate

   always_comb begin
      if (sum < SW'(MIN))      clamped = W'(MIN);
      else if (sum > SW'(MAX)) clamped = W'(MAX);
      else                     clamped = sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blank_q <= W'(DEF);
      else if (reload) blank_q <= W'(DEF);
      else if (commit) blank_q <= clamped;
   end

   assign blank = blank_q;

   // R6
   blank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_q >= W'(MIN)) && (blank_q <= W'(MAX)));

   // R12
   hold_unless_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !commit) |=> $stable(blank_q));

endmodule

// File: rtl/desat_guard.sv
module desat_guard
   import desat_pkg::*;
#(
   parameter int SYNC_N    = 2,
   parameter int FILT_LEN  = 4,
   parameter int BLANK_DEF = 60,
   parameter int BLANK_MIN = 25,
   parameter int BLANK_MAX = 250,
   parameter int MARGIN    = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               pwm_in,
   input  logic                               desat_in,
   input  logic                               clr_in,
   output logic                               gate_out,
   output logic                               fault_out,
   output logic [1:0]                         fault_code,
   output logic [$clog2(BLANK_MAX + 1)-1:0]   blank_len
);

   localparam int CW = $clog2(BLANK_MAX + 1);

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("desat_guard: SYNC_N must be at least 2");
      end
      if (FILT_LEN < 1 || FILT_LEN > 8) begin : g_bad_filt
         $error("desat_guard: FILT_LEN must lie in 1..8");
      end
      if (BLANK_MIN < 1 || BLANK_MIN > BLANK_MAX) begin : g_bad_range
         $error("desat_guard: blanking range is empty");
      end
      if (BLANK_DEF < BLANK_MIN || BLANK_DEF > BLANK_MAX) begin : g_bad_def
         $error("desat_guard: default blanking outside clamp range");
      end
   endgenerate

   logic          desat_s;
   logic          desat_f;
   logic          clr_ok;
   logic          commit;
   dg_state_e     st_q;
   dg_fcode_e     code_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] meas_q;
   logic [CW-1:0] blank_w;

   dg_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (desat_in),
      .q_out (desat_s)
   );

   dg_filter #(.LEN(FILT_LEN), .RST_VAL(1'b1)) filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_in    (desat_s),
      .lvl_out (desat_f)
   );

   assign clr_ok = clr_in && !pwm_in;
   assign commit = (st_q == DG_COND) && !pwm_in;

   dg_learn #(
      .W(CW), .DEF(BLANK_DEF), .MIN(BLANK_MIN), .MAX(BLANK_MAX), .MARGIN(MARGIN)
   ) learn_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (clr_ok),
      .commit (commit),
      .meas   (meas_q),
      .blank  (blank_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DG_IDLE;
         code_q <= DG_FC_NONE;
         cnt_q  <= '0;
         meas_q <= '0;
      end else if (clr_ok) begin
         st_q   <= DG_IDLE;
         code_q <= DG_FC_NONE;
         cnt_q  <= '0;
      end else begin
         unique case (st_q)
            DG_IDLE: begin
               if (pwm_in) begin
                  st_q  <= DG_RISE;
                  cnt_q <= CW'(1);
               end
            end
            DG_RISE: begin
               if (!pwm_in) begin
                  st_q <= DG_IDLE;
               end else if (!desat_f) begin
                  meas_q <= cnt_q;
                  st_q   <= DG_COND;
               end else if (cnt_q >= blank_w) begin
                  st_q   <= DG_TRIP;
                  code_q <= DG_FC_HARD;
               end else if (cnt_q != {CW{1'b1}}) begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            DG_COND: begin
               if (!pwm_in) begin
                  st_q <= DG_IDLE;
               end else if (desat_f) begin
                  st_q   <= DG_TRIP;
                  code_q <= DG_FC_LOAD;
               end
            end
            DG_TRIP: begin
               st_q <= DG_TRIP;
            end
            default: st_q <= DG_IDLE;
         endcase
      end
   end

   assign fault_out  = (st_q == DG_TRIP);
   assign gate_out   = pwm_in && (st_q != DG_TRIP);
   assign fault_code = code_q;
   assign blank_len  = blank_w;

   // R10
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_out && !clr_ok) |=> fault_out);

   // R9
   code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_out |-> ($countones(fault_code) == 1));

   // R9
   code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_out |-> (fault_code == 2'b00));

   // R11
   clear_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok |=> (!fault_out && (blank_len == CW'(BLANK_DEF))));

   // R4
   hard_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == DG_RISE) |-> (cnt_q <= blank_w));

   // R12
   short_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == DG_RISE && !pwm_in && !clr_in) |=> $stable(blank_len));

endmodule

// File: tb/desat_guard_tb.sv
`timescale 1ns/1ps
module desat_guard_tb_top;

   localparam int CLK_PERIOD = 4;
   localparam int MODEL_FILT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_in = 1'b0;
   logic       desat_in = 1'b1;
   logic       clr_in = 1'b0;
   logic       gate_out;
   logic       fault_out;
   logic [1:0] fault_code;
   logic [7:0] blank_len;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   desat_guard dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_in     (pwm_in),
      .desat_in   (desat_in),
      .clr_in     (clr_in),
      .gate_out   (gate_out),
      .fault_out  (fault_out),
      .fault_code (fault_code),
      .blank_len  (blank_len)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // behavioural reference: pipeline delays and phases as integers
   int m_s1 = 1, m_s2 = 1, m_lvl = 1, m_run = 0;
   int m_phase = 0;   // 0 idle, 1 waiting for fall, 2 conducting, 3 tripped
   int m_cnt = 0, m_meas = 0, m_blank = 60, m_code = 0;

   function automatic int clamp_blank(int v);
      if (v < 25) return 25;
      if (v > 250) return 250;
      return v;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_lvl = 1; m_run = 0;
         m_phase = 0; m_cnt = 0; m_meas = 0; m_blank = 60; m_code = 0;
      end else begin
         if (clr_in && !pwm_in) begin
            m_phase = 0; m_code = 0; m_cnt = 0; m_blank = 60;
         end else if (m_phase == 0) begin
            if (pwm_in) begin m_phase = 1; m_cnt = 1; end
         end else if (m_phase == 1) begin
            if (!pwm_in) m_phase = 0;
            else if (m_lvl == 0) begin m_meas = m_cnt; m_phase = 2; end
            else if (m_cnt >= m_blank) begin m_phase = 3; m_code = 1; end
            else if (m_cnt < 255) m_cnt++;
         end else if (m_phase == 2) begin
            if (!pwm_in) begin m_phase = 0; m_blank = clamp_blank(m_meas + 8); end
            else if (m_lvl == 1) begin m_phase = 3; m_code = 2; end
         end
         if (m_s2 == m_lvl) m_run = 0;
         else if (m_run == MODEL_FILT - 1) begin m_run = 0; m_lvl = m_s2; end
         else m_run++;
         m_s2 = m_s1;
         m_s1 = int'(desat_in);
      end
      #1;
      if (!done) begin
         chk(gate_out == (pwm_in && m_phase != 3), "R2 gate_out", gate_out,
             pwm_in && m_phase != 3);
         chk(fault_out == (m_phase == 3), "R10 fault_out", fault_out, m_phase == 3);
         chk(int'(fault_code) == m_code, "R9 fault_code", fault_code, m_code);
         chk(int'(blank_len) == m_blank, "R3 blank_len", blank_len, m_blank);
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one on-interval; indices count negedges after the turn-on drive
   task automatic period(int on_len, int fall_at, int ful_at, int g_at, int g_len,
                         bit chk_ful);
      for (int i = 0; i < on_len; i++) begin
         @(negedge clk);
         if (chk_ful && i == ful_at + 6) chk(gate_out == 1'b1, "R8 gate before cut", gate_out, 1);
         if (chk_ful && i == ful_at + 7) chk(gate_out == 1'b0, "R8 gate cut", gate_out, 0);
         begin
            bit v;
            v = (i < fall_at);
            if (ful_at >= 0 && i >= ful_at) v = 1'b1;
            if (g_len > 0 && i >= g_at && i < g_at + g_len) v = ~v;
            desat_in = v;
         end
         pwm_in = 1'b1;
      end
      @(negedge clk);
      pwm_in = 1'b0;
      desat_in = 1'b1;
      idle(20);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr_in = 1'b1;
      @(negedge clk);
      clr_in = 1'b0;
      idle(2);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual 1 expected 0 (run hung)");
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(5);
      chk(fault_out == 1'b0, "R1 fault at reset", fault_out, 0);
      chk(fault_code == 2'b00, "R1 code at reset", fault_code, 0);
      chk(gate_out == 1'b0, "R1 gate at reset", gate_out, 0);
      rst_n = 1'b1;
      idle(3);
      chk(blank_len == 8'd60, "R7 default window", blank_len, 60);

      // fast fall: 10 + 14 = 24, clamped up
      period(40, 10, -1, -1, 0, 1'b0);
      chk(blank_len == 8'd25, "R6 lower clamp", blank_len, 25);
      period(60, 15, -1, -1, 0, 1'b0);
      chk(blank_len == 8'd29, "R3 learned 15+14", blank_len, 29);
      period(60, 18, -1, -1, 0, 1'b0);
      chk(blank_len == 8'd32, "R5 window rises", blank_len, 32);
      period(60, 12, -1, -1, 0, 1'b0);
      chk(blank_len == 8'd26, "R5 window falls", blank_len, 26);

      // short pulses before and after the fall
      period(60, 12, -1, 3, 3, 1'b0);
      chk(fault_out == 1'b0, "R13 pre-fall pulse no fault", fault_out, 0);
      chk(blank_len == 8'd26, "R13 pre-fall pulse not a fall", blank_len, 26);
      period(80, 12, -1, 40, 3, 1'b0);
      chk(fault_out == 1'b0, "R13 post-fall pulse no fault", fault_out, 0);

      // on-time ends before the fall is seen
      period(10, 12, -1, -1, 0, 1'b0);
      chk(blank_len == 8'd26, "R12 short on-time keeps window", blank_len, 26);
      chk(fault_out == 1'b0, "R12 short on-time no fault", fault_out, 0);

      // fault under load
      period(80, 12, 40, -1, 0, 1'b1);
      chk(fault_out == 1'b1, "R8 under-load fault flag", fault_out, 1);
      chk(fault_code == 2'b10, "R9 under-load code", fault_code, 2);
      chk(blank_len == 8'd26, "R12 faulted period keeps window", blank_len, 26);

      // command high while tripped, clear refused while high
      @(negedge clk);
      pwm_in = 1'b1;
      clr_in = 1'b1;
      idle(1);
      clr_in = 1'b0;
      idle(5);
      chk(gate_out == 1'b0, "R10 gate held low", gate_out, 0);
      chk(fault_out == 1'b1, "R11 clear ignored with command high", fault_out, 1);
      pwm_in = 1'b0;
      idle(2);
      pulse_clear();
      chk(fault_out == 1'b0, "R11 clear with command low", fault_out, 0);
      chk(blank_len == 8'd60, "R11 clear restores default", blank_len, 60);

      // never falls: hard fault at default window
      period(100, 1000, -1, -1, 0, 1'b0);
      chk(fault_code == 2'b01, "R9 hard-switching code", fault_code, 1);
      pulse_clear();

      // learned short window catches a later fall
      period(40, 10, -1, -1, 0, 1'b0);
      period(60, 30, -1, -1, 0, 1'b0);
      chk(fault_out == 1'b1, "R4 learned window trips", fault_out, 1);
      chk(fault_code == 2'b01, "R4 hard code", fault_code, 1);
      pulse_clear();

      // stepped ramp into the upper clamp
      for (int f = 50; f <= 242; f += 8) begin
         period(f + 30, f, -1, -1, 0, 1'b0);
         chk(blank_len == 8'(clamp_blank(f + 14)), "R3 ramp step", blank_len,
             clamp_blank(f + 14));
      end
      chk(blank_len == 8'd250, "R6 upper clamp", blank_len, 250);
      chk(fault_out == 1'b0, "R5 ramp without fault", fault_out, 0);

      idle(4);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule